// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns a parallel data word into a self-clocking Manchester line signal. Each bit period holds a first half and a second half at opposite levels, so every bit has a transition at mid-bit. Before the data, the block can send a lead-in of 0 to 15 bit periods. The lead-in bits follow one of four fixed patterns and are coded exactly like data bits.

Timing comes from an external enable tick, with 16 ticks per bit period. A one-clock start strobe latches the word, its bit count and the frame settings. The frame settings are the transition convention, the lead-in length and the lead-in pattern. The frame then begins on the next enable tick. Busy covers the whole frame, and a one-clock done pulse marks its end.

Top module: `manch_tx`

## Requirements
- R1: With `pol`=0, a bit of value 0 has a low first half and a high second half. A bit of value 1 has a high first half and a low second half.
- R2: With `pol`=1, both codings are inverted. A 0 is high then low, and a 1 is low then high. Lead-in bits are inverted in the same way.
- R3: While `busy` is low, `line` equals the live `pol` input. Between the start strobe and the first tick, `line` holds the latched polarity.
- R4: `pre_len`=0 sends no lead-in. Values 1 to 15 send that many lead-in bit periods before the data.
- R5: `pre_pat` sets the lead-in bit values, counted from lead-in bit index 0. 2'b00 gives all 1. 2'b01 gives all 0. 2'b10 gives 0 on even indices and 1 on odd indices. 2'b11 gives 1 on even indices and 0 on odd indices.
- R6: A bit period is 16 ticks. The first-half level appears on the first tick of the bit, and the second-half level appears on its ninth tick. `line` never changes in a clock without `tick_en`.
- R7: Data is sent LSB first, starting at bit 0 of `data`. `nbits` sets the number of data bits. A value of 0, or a value above DATA_W, sends DATA_W bits.
- R8: A start strobe while idle raises `busy` on the next clock. The first bit of the frame begins on the first tick after that.
- R9: On the tick that would begin the bit after the last one, `done` is high for exactly one clock, `busy` falls, and `line` returns to the idle level. A strobe in that same clock begins a new frame.
- R10: A start strobe while `busy` is high has no effect on the frame in progress.
- R11: Asserting `rst_n` low clears `busy` and `done` at once. After release, the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Bit-rate enable, 16 per bit period |
| start | input | 1 | Frame start strobe |
| data | input | DATA_W | Word to transmit |
| nbits | input | $clog2(DATA_W+1) | Number of data bits |
| pol | input | 1 | Transition convention select |
| pre_len | input | 4 | Lead-in length in bit periods |
| pre_pat | input | 2 | Lead-in pattern select |
| line | output | 1 | Coded line signal |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |

## Verification
Two situations are hard to reach from the ports. The first is a start strobe that lands in the middle of a long frame. Some table rows inject a strobe with a different word and bit count partway through the frame, and the bench then checks that every half-bit of the original frame is still intact. The second is a strobe in the exact clock of the done pulse. The table rows run back to back, so every frame after the first is started in that clock. Some rows also hold back the first tick for several clocks, which exposes the wait between the strobe and the first bit.

// File: rtl/manch_pkg.sv
package manch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_PRE  = 2'd2,
    ST_DAT  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    PAT_ONES  = 2'b00,
    PAT_ZEROS = 2'b01,
    PAT_ZO    = 2'b10,
    PAT_OZ    = 2'b11
  } pre_pat_e;

  // Value of one lead-in bit; odd marks an odd bit index.
  function automatic logic pre_bit(input logic [1:0] pat, input logic odd);
    logic b;
    case (pat)
      PAT_ONES:  b = 1'b1;
      PAT_ZEROS: b = 1'b0;
      PAT_ZO:    b = odd;
      default:   b = ~odd;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/manch_rst_sync.sv
module manch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/manch_phase_ctr.sv
module manch_phase_ctr #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic bound,
  output logic mid
);
  localparam int PW   = $clog2(TICKS_PER_BIT);
  localparam int HALF = TICKS_PER_BIT / 2;

  logic [PW-1:0] phase_q, phase_d;
  logic          step;

  assign step = run && tick;

  always_comb begin
    phase_d = phase_q;
    if (clr)
      phase_d = '0;
    else if (step)
      phase_d = (phase_q == PW'(TICKS_PER_BIT - 1)) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign bound = step && (phase_q == '0);
  assign mid   = step && (phase_q == PW'(HALF));
endmodule

// File: rtl/manch_frame_seq.sv
module manch_frame_seq
  import manch_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [CW-1:0]     nbits,
  input  logic [3:0]        pre_len,
  input  logic [1:0]        pre_pat,
  input  logic              bound,
  output logic              accept,
  output logic              run,
  output logic              active,
  output logic              bit_go,
  output logic              bit_val,
  output logic              done
);
  seq_st_e           st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     left_q, left_d;
  logic [3:0]        pidx_q, pidx_d;
  logic [3:0]        len_q, len_d;
  logic [1:0]        pat_q, pat_d;
  logic              done_q, done_d;
  logic              take_data;
  logic [CW-1:0]     eff_n;

  assign eff_n = ((nbits == '0) || (nbits > CW'(DATA_W))) ? CW'(DATA_W) : nbits;
  assign accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d      = st_q;
    sh_d      = sh_q;
    left_d    = left_q;
    pidx_d    = pidx_q;
    len_d     = len_q;
    pat_d     = pat_q;
    done_d    = 1'b0;
    bit_go    = 1'b0;
    bit_val   = 1'b0;
    take_data = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_ARM;
          sh_d   = data;
          left_d = eff_n;
          len_d  = pre_len;
          pat_d  = pre_pat;
          pidx_d = '0;
        end
      end
      ST_ARM: begin
        if (bound) begin
          bit_go = 1'b1;
          if (len_q != '0) begin
            bit_val = pre_bit(pat_q, 1'b0);
            pidx_d  = 4'd1;
            st_d    = ST_PRE;
          end else begin
            take_data = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (bound) begin
          bit_go = 1'b1;
          if (pidx_q == len_q) begin
            take_data = 1'b1;
          end else begin
            bit_val = pre_bit(pat_q, pidx_q[0]);
            pidx_d  = pidx_q + 1'b1;
          end
        end
      end
      default: begin
        if (bound) begin
          if (left_q == '0) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            bit_go    = 1'b1;
            take_data = 1'b1;
          end
        end
      end
    endcase
    if (take_data) begin
      bit_val = sh_q[0];
      sh_d    = sh_q >> 1;
      left_d  = left_q - 1'b1;
      st_d    = ST_DAT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      pidx_q <= '0;
      len_q  <= '0;
      pat_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      pidx_q <= pidx_d;
      len_q  <= len_d;
      pat_q  <= pat_d;
      done_q <= done_d;
    end
  end

  assign run    = (st_q != ST_IDLE);
  assign active = (st_q == ST_PRE) || (st_q == ST_DAT);
  assign done   = done_q;
endmodule

// File: rtl/manch_line_enc.sv
module manch_line_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic pol,
  input  logic run,
  input  logic active,
  input  logic bit_go,
  input  logic bit_val,
  input  logic mid,
  output logic line
);
  logic pol_q, pol_d;
  logic lvl_q, lvl_d;

  always_comb begin
    pol_d = accept ? pol : pol_q;
    lvl_d = lvl_q;
    if (bit_go)   lvl_d = bit_val ^ pol_q;
    else if (mid) lvl_d = ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      pol_q <= pol_d;
      lvl_q <= lvl_d;
    end
  end

  assign line = active ? lvl_q : (run ? pol_q : pol);
endmodule

// File: rtl/manch_tx.sv
module manch_tx #(
  parameter int DATA_W        = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int CW           = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [CW-1:0]     nbits,
  input  logic              pol,
  input  logic [3:0]        pre_len,
  input  logic [1:0]        pre_pat,
  output logic              line,
  output logic              busy,
  output logic              done
);
  logic rst_s;
  logic accept, run, active, bit_go, bit_val, bound, mid;

  manch_rst_sync #(.STAGES(2)) i_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  manch_phase_ctr #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_phase (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (accept),
    .run   (run),
    .tick  (tick_en),
    .bound (bound),
    .mid   (mid)
  );

  manch_frame_seq #(.DATA_W(DATA_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_s),
    .start   (start),
    .data    (data),
    .nbits   (nbits),
    .pre_len (pre_len),
    .pre_pat (pre_pat),
    .bound   (bound),
    .accept  (accept),
    .run     (run),
    .active  (active),
    .bit_go  (bit_go),
    .bit_val (bit_val),
    .done    (done)
  );

  manch_line_enc i_enc (
    .clk     (clk),
    .rst_n   (rst_s),
    .accept  (accept),
    .pol     (pol),
    .run     (run),
    .active  (active),
    .bit_go  (bit_go),
    .bit_val (bit_val),
    .mid     (mid),
    .line    (line)
  );

  assign busy = run;
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk (
  input logic clk,
  input logic rst_s,
  input logic tick_en,
  input logic start,
  input logic pol,
  input logic line,
  input logic busy,
  input logic done
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!busy && $past(busy)));

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> (line == pol));

  // R6
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy) && !$past(tick_en)) |-> $stable(line));

  // R6
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> $past(tick_en));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && start) |=> busy);

  // R10
  start_ign_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start && !tick_en) |=> busy);
endmodule

bind manch_tx manch_tx_chk i_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .tick_en (tick_en),
  .start   (start),
  .pol     (pol),
  .line    (line),
  .busy    (busy),
  .done    (done)
);

// File: tb/test_manch_tx.sv
module test_manch_tx;
  localparam int DATA_W = 16;
  localparam int CW     = $clog2(DATA_W + 1);
  localparam int NV     = 8;

  // {data, nbits, pol, pre_len, pre_pat, inject, gap}
  localparam logic [31:0] VEC [NV] = '{
    {16'hA5C3, 5'd8,  1'b0, 4'd0,  2'd0, 1'b0, 3'd2},
    {16'h00F1, 5'd12, 1'b1, 4'd0,  2'd0, 1'b0, 3'd0},
    {16'h1234, 5'd16, 1'b0, 4'd4,  2'd0, 1'b0, 3'd1},
    {16'hBEEF, 5'd5,  1'b0, 4'd7,  2'd1, 1'b0, 3'd0},
    {16'h0F0F, 5'd9,  1'b1, 4'd3,  2'd2, 1'b0, 3'd3},
    {16'h8001, 5'd0,  1'b0, 4'd15, 2'd3, 1'b1, 3'd0},
    {16'hFFFF, 5'd20, 1'b1, 4'd1,  2'd3, 1'b0, 3'd5},
    {16'h0001, 5'd1,  1'b1, 4'd2,  2'd2, 1'b1, 3'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic [CW-1:0]     nbits = '0;
  logic              pol = 1'b0;
  logic [3:0]        pre_len = '0;
  logic [1:0]        pre_pat = '0;
  logic              line, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  manch_tx #(.DATA_W(DATA_W)) i_manch_tx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
    .data(data), .nbits(nbits), .pol(pol), .pre_len(pre_len),
    .pre_pat(pre_pat), .line(line), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic run_frame(input int vi, input logic [31:0] v);
    logic [15:0] d;
    logic [4:0]  nb;
    logic        p;
    logic [3:0]  ln;
    logic [1:0]  pt;
    logic        inj;
    logic [2:0]  gap;
    int          eff, tot, last, wave_bad, hold_bad, flag_bad, first_t, got_l, exp_l;
    logic        expb [32];
    d = v[31:16]; nb = v[15:11]; p = v[10]; ln = v[9:6]; pt = v[5:4];
    inj = v[3]; gap = v[2:0];
    eff = (nb == 0 || nb > DATA_W) ? DATA_W : int'(nb);
    tot = int'(ln) + eff;
    for (int i = 0; i < int'(ln); i++) begin
      case (pt)
        2'b00: expb[i] = 1'b1;
        2'b01: expb[i] = 1'b0;
        2'b10: expb[i] = (i % 2) == 1;
        default: expb[i] = (i % 2) == 0;
      endcase
    end
    for (int j = 0; j < eff; j++) expb[int'(ln) + j] = d[j];
    wave_bad = 0; hold_bad = 0; flag_bad = 0; first_t = 0; got_l = 0; exp_l = 0;
    // strobe in the current clock (back to back with previous done)
    data = d; nbits = nb; pol = p; pre_len = ln; pre_pat = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: busy on next clock, line at idle level until first tick
    chk(busy === 1'b1 && line === p, "R8 busy after start", int'(busy), 1);
    for (int g = 0; g < int'(gap); g++) begin
      @(negedge clk);
      if (line !== p || busy !== 1'b1) flag_bad++;
    end
    last = tot * 16 + 1;
    for (int t = 1; t <= last; t++) begin
      logic lv;
      logic e;
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      start = 1'b0;
      if (t < last) begin
        int k;
        int w;
        k = (t - 1) / 16;
        w = (t - 1) % 16;
        e = (w < 8) ? (expb[k] ^ p) : ~(expb[k] ^ p);
        if (line !== e) begin
          if (wave_bad == 0) begin first_t = t; got_l = int'(line); exp_l = int'(e); end
          wave_bad++;
        end
        if (busy !== 1'b1 || done !== 1'b0) flag_bad++;
        lv = line;
        if (inj && t == 40) begin
          // R10: foreign strobe mid-frame
          start = 1'b1; data = ~d; nbits = 5'd3;
        end
        @(negedge clk);
        if (line !== lv) hold_bad++;
      end
    end
    chk(wave_bad == 0, $sformatf("R1 R2 R4 R5 R7 R10 waveform vec=%0d tick=%0d", vi, first_t),
        got_l, exp_l);
    chk(hold_bad == 0, $sformatf("R6 line held between ticks vec=%0d", vi), hold_bad, 0);
    chk(flag_bad == 0, $sformatf("R8 busy/done during frame vec=%0d", vi), flag_bad, 0);
    chk(done === 1'b1 && busy === 1'b0, $sformatf("R9 end of frame vec=%0d", vi),
        int'({done, busy}), 2);
    chk(line === p, $sformatf("R3 line idle after frame vec=%0d", vi), int'(line), int'(p));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy === 1'b0 && done === 1'b0, "R11 reset state", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && line === 1'b0, "R11 idle after release",
        int'({busy, done, line}), 0);
    // R3: idle level tracks polarity input
    pol = 1'b1;
    #1;
    chk(line === 1'b1, "R3 idle follows pol=1", int'(line), 1);
    pol = 1'b0;
    #1;
    chk(line === 1'b0, "R3 idle follows pol=0", int'(line), 0);
    @(negedge clk);

    for (int vi = 0; vi < NV; vi++) run_frame(vi, VEC[vi]);

    @(negedge clk);
    chk(done === 1'b0, "R9 done lasts one clock", int'(done), 0);

    // R11: reset in mid-frame
    data = 16'h5555; nbits = 5'd16; pre_len = 4'd2; pre_pat = 2'd0; pol = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 30; t++) begin
      tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
    end
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R11 async clear mid-frame", int'({busy, done}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && line === 1'b1, "R11 idle after mid-frame reset",
        int'({busy, line}), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule